// File: doc/BRIEF.md
# Cascadable Synchronous Loadable Counter

This block is a binary counter built from identical 4-bit slices that share one clock. Each slice can be cleared, loaded in parallel, or advanced by one. A slice advances only when two enables are both true. The first is a master enable that goes to every slice. The second is a chain enable that comes from the slice below.

Each slice drives a terminal-count flag. The flag is true when the slice holds all ones and its chain enable is true. That flag feeds the chain enable of the next slice up. A wide count therefore advances in one clock, with no ripple between slices.

The top level joins three slices into a 12-bit counter. Clear and load act on all slices at once, and the 12-bit load value is split into nibbles. The top slice's terminal count is brought out as a carry-out.

Top module: `cascade_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` becomes 0 after that edge.
- R2: When `clr` is high at a rising edge, `count` becomes 0 after that edge, whatever `load` and `cnt_en` are.
- R3: When `clr` is low and `load` is high at a rising edge, `count` takes the value of `load_val` after that edge, whatever `cnt_en` is.
- R4: When `clr` and `load` are low and `cnt_en` is high at a rising edge, `count` increases by exactly 1 after that edge.
- R5: When `clr`, `load` and `cnt_en` are all low at a rising edge, `count` keeps its value.
- R6: `carry_out` is high exactly when `count` is 0xFFF, independent of `cnt_en`, with no clock delay.
- R7: Counting from 0xFFF wraps `count` to 0x000.
- R8: A nibble of `count` changes on an increment only when every lower nibble is 0xF, so 0x0EF goes to 0x0F0 and 0x0FF goes to 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load |
| load_val | input | 12 | Parallel load value |
| cnt_en | input | 1 | Master count enable to all slices |
| count | output | 12 | Current count |
| carry_out | output | 1 | Terminal count of the top slice |

## Verification
The counter is loaded just below nibble boundaries (0x0EF, 0x0FF, 0xFFE) and then counted. These runs show whether the chain enable carries into exactly the right nibble and whether the count wraps correctly.

Clear is applied together with load and enable, and load together with enable. These cases separate the three priority levels.

A run with the enable held low at 0xFFF shows that the carry does not depend on the master enable. A long free count covers every low-nibble carry pattern.

// File: rtl/cnt_pkg.sv
// Package: shared types for the cascadable counter.
// Assumes: nothing beyond IEEE 1800-2017.
package cnt_pkg;
    // Action taken by one slice at a clock edge, in fixed priority order.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_CLR  = 2'd1,
        ACT_LOAD = 2'd2,
        ACT_INC  = 2'd3
    } slice_act_t;
endpackage

// File: rtl/slice_next.sv
// Module: slice_next
// Computes the next value of one slice from its control inputs.
// Priority is clear, then load, then increment, then hold.
// Assumes: purely combinational, with the width set by W.
module slice_next #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] d,
    input  logic         inc,
    output logic [W-1:0] nxt
);
    import cnt_pkg::*;

    slice_act_t act;

    // Decode the fixed priority into a single action.
    always_comb begin
        if (clr)       act = ACT_CLR;
        else if (load) act = ACT_LOAD;
        else if (inc)  act = ACT_INC;
        else           act = ACT_HOLD;
    end

    // Select the next value for the decoded action.
    always_comb begin
        case (act)
            ACT_CLR:  nxt = '0;
            ACT_LOAD: nxt = d;
            ACT_INC:  nxt = cur + W'(1);
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/count_slice.sv
// Module: count_slice
// One W-bit synchronous counter slice with two count enables.
// Its terminal-count flag is gated by the chain enable only.
// Assumes: the synchronous active-low reset is on the shared clock.
module count_slice #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] d,
    input  logic         en_master,
    input  logic         en_chain,
    output logic [W-1:0] q,
    output logic         tc
);
    logic [W-1:0] q_nxt;

    slice_next #(.W(W)) u_next (
        .cur  (q),
        .clr  (clr),
        .load (load),
        .d    (d),
        .inc  (en_master & en_chain),
        .nxt  (q_nxt)
    );

    // Slice state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    // Terminal count: all ones and enabled from below.
    assign tc = (&q) & en_chain;
endmodule

// File: rtl/cascade_counter.sv
// Module: cascade_counter
// Chains NUM_SLICES counter slices into one wide synchronous counter.
// Each slice's chain enable is the terminal count of the slice below.
// The lowest chain enable is tied high.
// Assumes: one shared clock and a synchronous active-low reset.
module cascade_counter #(
    parameter int SLICE_W    = 4,
    parameter int NUM_SLICES = 3,
    localparam int CW        = SLICE_W * NUM_SLICES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          cnt_en,
    output logic [CW-1:0] count,
    output logic          carry_out
);
    logic [NUM_SLICES:0] chain;

    // Lowest slice is always enabled from below.
    assign chain[0] = 1'b1;

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        count_slice #(.W(SLICE_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .load      (load),
            .d         (load_val[i*SLICE_W +: SLICE_W]),
            .en_master (cnt_en),
            .en_chain  (chain[i]),
            .q         (count[i*SLICE_W +: SLICE_W]),
            .tc        (chain[i+1])
        );
    end

    assign carry_out = chain[NUM_SLICES];
endmodule

// File: rtl/cascade_counter_chk.sv
// Module: cascade_counter_chk
// Temporal checks on the ports of cascade_counter, bound to every instance.
// Assumes: the synchronous active-low reset is on the same clock.
module cascade_counter_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr,
    input logic          load,
    input logic [CW-1:0] load_val,
    input logic          cnt_en,
    input logic [CW-1:0] count,
    input logic          carry_out
);
    // R2: clear wins over everything
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R3: load copies the value and overrides counting
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load) |=> (count == $past(load_val)));

    // R4 and R7: the enabled count steps by one, modulo 2^CW
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && cnt_en) |=> (count == CW'($past(count) + CW'(1))));

    // R5: the count holds with no control active
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load && !cnt_en) |=> $stable(count));

    // R6: the carry tracks the all-ones count
    p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out == (&count));
endmodule

bind cascade_counter cascade_counter_chk #(.CW(SLICE_W * NUM_SLICES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .load      (load),
    .load_val  (load_val),
    .cnt_en    (cnt_en),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/cascade_counter_test.sv
// Bench: cascade_counter_test
// Behavioural reference model, compared on every clock.
module cascade_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        load = 1'b0;
    logic [11:0] load_val = '0;
    logic        cnt_en = 1'b0;
    logic [11:0] count;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 0;

    cascade_counter uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(load),
        .load_val(load_val), .cnt_en(cnt_en),
        .count(count), .carry_out(carry_out)
    );

    always #4 clk = ~clk;

    // Compare the count and the carry against the model.
    task automatic compare(input string tag);
        checks++;
        if (count !== 12'(model)) begin
            fails++;
            $display("FAIL %s count actual=%h expected=%h", tag, count, 12'(model));
        end
        checks++;
        if (carry_out !== (model == 12'hFFF)) begin
            fails++;
            $display("FAIL R6 (%s) carry actual=%b expected=%b", tag, carry_out, model == 12'hFFF);
        end
    endtask

    // Apply the inputs at a falling edge, clock once, update the model, then check.
    task automatic step(input bit r, input bit c, input bit l, input logic [11:0] v,
                        input bit e, input string tag);
        rst_n = r; clr = c; load = l; load_val = v; cnt_en = e;
        @(posedge clk);
        if (!r)      model = 0;
        else if (c)  model = 0;
        else if (l)  model = int'(v);
        else if (e)  model = (model + 1) % 4096;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        @(negedge clk);
        step(0, 0, 0, 12'h000, 0, "R1");
        step(0, 0, 1, 12'h5A5, 1, "R1");
        // R3: load, and load over enable
        step(1, 0, 1, 12'h0EF, 0, "R3");
        step(1, 0, 1, 12'h0EF, 1, "R3");
        // R8: carry into the middle nibble only
        step(1, 0, 0, 12'h000, 1, "R8");
        step(1, 0, 1, 12'h0FF, 0, "R3");
        // R8: carry into the top nibble
        step(1, 0, 0, 12'h000, 1, "R8");
        // R5: hold
        for (int i = 0; i < 3; i++) step(1, 0, 0, 12'hFFF, 0, "R5");
        // R6: carry with the enable low at all ones
        step(1, 0, 1, 12'hFFF, 0, "R6");
        step(1, 0, 0, 12'h000, 0, "R6");
        // R7: wrap
        step(1, 0, 1, 12'hFFE, 0, "R3");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 12'h000, 1, "R7");
        // R2: clear over load and enable
        step(1, 0, 1, 12'h123, 0, "R3");
        step(1, 1, 1, 12'h777, 1, "R2");
        step(1, 0, 1, 12'h3F0, 0, "R3");
        step(1, 1, 0, 12'h000, 0, "R2");
        // R4: long free count
        for (int i = 0; i < 600; i++) step(1, 0, 0, 12'h000, 1, "R4");
        // R1: reset during counting
        step(0, 0, 0, 12'h000, 1, "R1");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule